// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial line back into characters. A sample tick, generated elsewhere at 16 or 8 times the bit rate, strobes the line once per tick. While idle the receiver looks for a falling edge, and it only looks once the line has stayed high for a few samples. It confirms each start bit by a three-sample majority vote. After that it takes every data, parity and stop bit as a majority of three samples near the middle of the bit period.

A finished character is moved into a holding register and raises a ready flag. Four status flags travel with the character: noise, framing, parity and overrun. A one-cycle read strobe drops the ready flag and the overrun flag. The word length can be eight or nine bits. Parity is optional and can be even or odd. The oversampling rate is picked by an input. The mode inputs must be held steady while a character is being received.

Top module: `serial_rx_os`

## Requirements
- R1: After reset, ready_o, overrun_o, noise_o, frame_o, parity_o are 0 and data_o is 0.
- R2: A start edge is accepted only if, while hunting, at least three consecutive high samples were seen directly before the first low sample. Fewer high samples leave the receiver hunting, and no character results.
- R3: Samples are numbered from 1 at the first low sample. With os8_i=0 the start is judged on samples 3, 5 and 7; with os8_i=1 on samples 2, 3 and 4. If fewer than two of them are low, the receiver goes back to hunting and no character results.
- R4: A bit period lasts 16 samples (os8_i=0) or 8 samples (os8_i=1). Each data bit is the majority of samples 8, 9 and 10 (os8_i=0) or 4, 5 and 6 (os8_i=1) of its period. The first data bit received lands in data_o[0].
- R5: nine_i=1 receives 9 data bits into data_o[8:0]. nine_i=0 receives 8 bits into data_o[7:0], with data_o[8]=0.
- R6: With par_en_i=1, one parity bit follows the data. par_odd_i=0 means even parity (data ones plus the parity bit give an even count) and par_odd_i=1 means odd. A mismatch sets parity_o together with ready_o. With par_en_i=0, parity_o stays 0.
- R7: The stop bit is voted at the data-bit positions. A low majority sets frame_o for that character.
- R8: noise_o is set for a character if the three samples of any of its votes (start, data, parity or stop) do not all agree. The majority value is still used.
- R9: ready_o rises in the cycle after the stop vote. A one-cycle rd_i clears ready_o and overrun_o.
- R10: If a character completes while ready_o is 1 and rd_i is 0, overrun_o is set. The held data and its flags stay unchanged and the new character is dropped.
- R11: A start bit that begins directly after the previous stop bit, with no idle samples in between, is received at both oversampling rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle sample strobe at 16x or 8x the bit rate |
| rxd_i | input | 1 | Serial line, synchronous to clk, idle high |
| os8_i | input | 1 | 1: 8x oversampling, 0: 16x |
| nine_i | input | 1 | 1: nine data bits, 0: eight |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| rd_i | input | 1 | Read strobe, clears ready and overrun |
| data_o | output | 9 | Received character |
| ready_o | output | 1 | Holding register holds an unread character |
| noise_o | output | 1 | A vote of the held character was not unanimous |
| frame_o | output | 1 | Stop bit of the held character was low |
| parity_o | output | 1 | Parity mismatch on the held character |
| overrun_o | output | 1 | A character was lost while ready was set |

## Verification
The bench tries starts that should be refused. One is a low pulse that covers too few vote positions, which a receiver judging the wrong samples would accept as a character. Another is a falling edge after only two idle highs, which a receiver without the idle rule would take. It flips single samples on and off the vote positions. A design with wrong positions would then either corrupt the data or report noise wrongly. It also sends characters back to back with no idle at 8x. A receiver that has to see fresh idle samples after the stop vote would lose the second character and so never flag the overrun. The overrun test checks that the first character survives, where a wrong design would overwrite it. Random characters mix word length, parity sense and rate, with both good and bad parity bits.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int RX_WORD_MAX = 9;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [RX_WORD_MAX-1:0] data;
    logic                   noise;
    logic                   frame;
    logic                   parity;
  } rx_char_t;
endpackage

// File: rtl/serial_rx_rstsync.sv
module serial_rx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic maj_o,
  output logic split_o
);
  always_comb begin
    maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    split_o = (a_i ^ b_i) | (a_i ^ c_i);
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OS_HI = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic     os8_i,
  input  logic     nine_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  output logic     hunt_o,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int OS_LO = OS_HI / 2;
  localparam int CW    = $clog2(OS_HI + 1);
  localparam int BW    = $clog2(RX_WORD_MAX + 1);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] N_HI  = CW'(OS_HI);
  localparam logic [CW-1:0] N_LO  = CW'(OS_LO);
  // start vote positions
  localparam logic [CW-1:0] SH1 = CW'(OS_HI / 4 - 1);
  localparam logic [CW-1:0] SH2 = CW'(OS_HI / 4 + 1);
  localparam logic [CW-1:0] SH3 = CW'(OS_HI / 4 + 3);
  localparam logic [CW-1:0] SL1 = CW'(OS_LO / 4);
  localparam logic [CW-1:0] SL2 = CW'(OS_LO / 4 + 1);
  localparam logic [CW-1:0] SL3 = CW'(OS_LO / 4 + 2);
  // mid-bit vote positions
  localparam logic [CW-1:0] DH1 = CW'(OS_HI / 2);
  localparam logic [CW-1:0] DH2 = CW'(OS_HI / 2 + 1);
  localparam logic [CW-1:0] DH3 = CW'(OS_HI / 2 + 2);
  localparam logic [CW-1:0] DL1 = CW'(OS_LO / 2);
  localparam logic [CW-1:0] DL2 = CW'(OS_LO / 2 + 1);
  localparam logic [CW-1:0] DL3 = CW'(OS_LO / 2 + 2);
  localparam logic [BW-1:0] LAST9 = BW'(RX_WORD_MAX - 1);
  localparam logic [BW-1:0] LAST8 = BW'(RX_WORD_MAX - 2);

  rx_state_e              state_q, state_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [BW-1:0]          bit_q, bit_d;
  logic [1:0]             hi_q, hi_d;
  logic [1:0]             v_q, v_d;
  logic [RX_WORD_MAX-1:0] sh_q, sh_d;
  logic                   noise_q, noise_d;
  logic                   pbit_q, pbit_d;

  logic [CW-1:0]          nsamp, pos, p1, p2, p3;
  logic [BW-1:0]          last_bit;
  logic                   maj, split, frame_err;
  logic [RX_WORD_MAX-1:0] word;

  serial_rx_vote u_vote (
    .a_i    (v_q[0]),
    .b_i    (v_q[1]),
    .c_i    (rxd_i),
    .maj_o  (maj),
    .split_o(split)
  );

  always_comb begin
    nsamp    = os8_i ? N_LO : N_HI;
    pos      = (cnt_q == nsamp) ? ONE : cnt_q + ONE;
    last_bit = nine_i ? LAST9 : LAST8;
    if (state_q == ST_START) begin
      p1 = os8_i ? SL1 : SH1;
      p2 = os8_i ? SL2 : SH2;
      p3 = os8_i ? SL3 : SH3;
    end else begin
      p1 = os8_i ? DL1 : DH1;
      p2 = os8_i ? DL2 : DH2;
      p3 = os8_i ? DL3 : DH3;
    end
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    hi_d      = hi_q;
    v_d       = v_q;
    sh_d      = sh_q;
    noise_d   = noise_q;
    pbit_d    = pbit_q;
    done_o    = 1'b0;
    frame_err = 1'b0;
    if (tick_i) begin
      if (state_q == ST_HUNT) begin
        if (!rxd_i && hi_q == 2'd3) begin
          state_d = ST_START;
          cnt_d   = ONE;
          bit_d   = '0;
          noise_d = 1'b0;
        end else if (rxd_i) begin
          if (hi_q != 2'd3) hi_d = hi_q + 2'd1;
        end else begin
          hi_d = 2'd0;
        end
      end else begin
        cnt_d = pos;
        if (pos == p1) v_d[0] = rxd_i;
        if (pos == p2) v_d[1] = rxd_i;
        if (pos == p3) begin
          case (state_q)
            ST_START: begin
              if (maj) begin
                state_d = ST_HUNT;
                hi_d    = 2'd0;
              end else begin
                noise_d = noise_q | split;
              end
            end
            ST_DATA: begin
              sh_d    = {maj, sh_q[RX_WORD_MAX-1:1]};
              noise_d = noise_q | split;
            end
            ST_PAR: begin
              pbit_d  = maj;
              noise_d = noise_q | split;
            end
            ST_STOP: begin
              done_o    = 1'b1;
              frame_err = ~maj;
              state_d   = ST_HUNT;
              hi_d      = maj ? 2'd3 : 2'd0;
            end
            default: ;
          endcase
        end else if (pos == ONE) begin
          case (state_q)
            ST_START: begin
              state_d = ST_DATA;
              bit_d   = '0;
            end
            ST_DATA: begin
              if (bit_q == last_bit) state_d = par_en_i ? ST_PAR : ST_STOP;
              else                   bit_d   = bit_q + BW'(1);
            end
            ST_PAR:  state_d = ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      bit_q   <= '0;
      hi_q    <= '0;
      v_q     <= '0;
      sh_q    <= '0;
      noise_q <= 1'b0;
      pbit_q  <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      hi_q    <= hi_d;
      v_q     <= v_d;
      sh_q    <= sh_d;
      noise_q <= noise_d;
      pbit_q  <= pbit_d;
    end
  end

  always_comb begin
    word          = nine_i ? sh_q : {1'b0, sh_q[RX_WORD_MAX-1:1]};
    char_o.data   = word;
    char_o.noise  = noise_q | split;
    char_o.frame  = frame_err;
    char_o.parity = par_en_i & (^word ^ pbit_q ^ par_odd_i);
    hunt_o        = (state_q == ST_HUNT);
  end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  logic     rd_i,
  input  rx_char_t char_i,
  output logic     ready_o,
  output logic     overrun_o,
  output rx_char_t char_o
);
  logic     ready_q, ready_d;
  logic     ovr_q, ovr_d;
  rx_char_t char_q, char_d;
  logic     accept;

  always_comb begin
    accept  = load_i & (~ready_q | rd_i);
    ready_d = accept ? 1'b1 : (rd_i ? 1'b0 : ready_q);
    ovr_d   = (load_i & ready_q & ~rd_i) ? 1'b1 : (rd_i ? 1'b0 : ovr_q);
    char_d  = accept ? char_i : char_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
      char_q  <= char_d;
    end
  end

  assign ready_o   = ready_q;
  assign overrun_o = ovr_q;
  assign char_o    = char_q;
endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os
  import serial_rx_pkg::*;
#(
  parameter int OS_HI = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   rxd_i,
  input  logic                   os8_i,
  input  logic                   nine_i,
  input  logic                   par_en_i,
  input  logic                   par_odd_i,
  input  logic                   rd_i,
  output logic [RX_WORD_MAX-1:0] data_o,
  output logic                   ready_o,
  output logic                   noise_o,
  output logic                   frame_o,
  output logic                   parity_o,
  output logic                   overrun_o
);
  logic     rst_ns;
  logic     hunt_w;
  logic     done_w;
  rx_char_t new_char;
  rx_char_t held_char;

  serial_rx_rstsync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  serial_rx_core #(.OS_HI(OS_HI)) u_core (
    .clk      (clk),
    .rst_n    (rst_ns),
    .tick_i   (tick_i),
    .rxd_i    (rxd_i),
    .os8_i    (os8_i),
    .nine_i   (nine_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .hunt_o   (hunt_w),
    .done_o   (done_w),
    .char_o   (new_char)
  );

  serial_rx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load_i   (done_w),
    .rd_i     (rd_i),
    .char_i   (new_char),
    .ready_o  (ready_o),
    .overrun_o(overrun_o),
    .char_o   (held_char)
  );

  assign data_o   = held_char.data;
  assign noise_o  = held_char.noise;
  assign frame_o  = held_char.frame;
  assign parity_o = held_char.parity;
endmodule

// File: rtl/serial_rx_os_chk.sv
module serial_rx_os_chk
  import serial_rx_pkg::*;
(
  input logic                   clk,
  input logic                   rst_ns,
  input logic                   tick_i,
  input logic                   rxd_i,
  input logic                   rd_i,
  input logic                   hunt_w,
  input logic                   done_w,
  input logic                   ready_o,
  input logic                   overrun_o,
  input logic [RX_WORD_MAX-1:0] data_o
);
  // R2: hunting ends only on a sampled low level
  a_r2_hunt_leaves_on_low: assert property (@(posedge clk) disable iff (!rst_ns)
    (hunt_w && !(tick_i && !rxd_i)) |=> hunt_w);

  // R9: a completed character raises ready
  a_r9_ready_on_done: assert property (@(posedge clk) disable iff (!rst_ns)
    done_w |=> ready_o);

  // R9: a read with no completion clears ready and overrun
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_i && !done_w) |=> (!ready_o && !overrun_o));

  // R10: unread data stays put
  a_r10_held_stable: assert property (@(posedge clk) disable iff (!rst_ns)
    (ready_o && !rd_i) |=> $stable(data_o));

  // R10: completion over unread data flags overrun
  a_r10_overrun_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_w && ready_o && !rd_i) |=> overrun_o);

  // R10: overrun only exists alongside held data
  a_r10_overrun_has_ready: assert property (@(posedge clk) disable iff (!rst_ns)
    overrun_o |-> ready_o);
endmodule

bind serial_rx_os serial_rx_os_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .tick_i   (tick_i),
  .rxd_i    (rxd_i),
  .rd_i     (rd_i),
  .hunt_w   (hunt_w),
  .done_w   (done_w),
  .ready_o  (ready_o),
  .overrun_o(overrun_o),
  .data_o   (data_o)
);

// File: tb/serial_rx_os_test.sv
module serial_rx_os_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, rxd, os8, nine, pen, podd, rd;
  logic [8:0] data;
  logic       ready, noise, frame, parity, overrun;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  serial_rx_os uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd), .os8_i(os8),
    .nine_i(nine), .par_en_i(pen), .par_odd_i(podd), .rd_i(rd),
    .data_o(data), .ready_o(ready), .noise_o(noise), .frame_o(frame),
    .parity_o(parity), .overrun_o(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nsamp();
    return os8 ? 8 : 16;
  endfunction

  function automatic bit is_vote(input int bi, input int p);
    if (bi == 0) return os8 ? (p >= 2 && p <= 4) : (p == 3 || p == 5 || p == 7);
    return os8 ? (p >= 4 && p <= 6) : (p >= 8 && p <= 10);
  endfunction

  function automatic logic [8:0] mask_word(input logic [8:0] d);
    return nine ? d : {1'b0, d[7:0]};
  endfunction

  task automatic samp(input bit v);
    @(negedge clk); rxd = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) samp(1'b1);
  endtask

  task automatic send_char(input logic [8:0] d, input int fbit, input int fpos,
                           input bit bad_par, input bit bad_stop);
    logic [8:0] dm;
    int nb, total;
    bit val;
    dm = mask_word(d);
    nb = nine ? 9 : 8;
    total = nb + (pen ? 1 : 0) + 2;
    for (int bi = 0; bi < total; bi++) begin
      if (bi == 0) val = 1'b0;
      else if (bi <= nb) val = dm[bi-1];
      else if (pen && bi == nb + 1) val = (^dm) ^ podd ^ bad_par;
      else val = ~bad_stop;
      for (int s = 1; s <= nsamp(); s++) samp(val ^ (bi == fbit && s == fpos));
    end
  endtask

  task automatic expect_char(input string req, input logic [8:0] d, input bit en,
                             input bit ef, input bit ep, input bit eo);
    chk(req, "ready", ready, 1);
    chk(req, "data", data, mask_word(d));
    chk(req, "noise", noise, en);
    chk(req, "frame", frame, ef);
    chk(req, "parity", parity, ep);
    chk(req, "overrun", overrun, eo);
  endtask

  task automatic do_read(input string req);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(req, "ready after read", ready, 0);
    chk(req, "overrun after read", overrun, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [8:0] a, b;
    int seed, fb, fp, nb;
    bit bp, en;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0; tick = 1'b0; rxd = 1'b0; rd = 1'b0;
    os8 = 1'b0; nine = 1'b0; pen = 1'b0; podd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "ready", ready, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "flags", {noise, frame, parity}, 0);
    chk("R1", "data", data, 0);

    // R2: only two highs before the edge, then a long low
    for (int i = 0; i < 5; i++) samp(1'b0);
    samp(1'b1); samp(1'b1);
    for (int i = 0; i < 40; i++) samp(1'b0);
    idle(30);
    chk("R2", "ready after unarmed edge", ready, 0);

    // R3: short low pulses are refused at both rates
    samp(1'b0); samp(1'b0); idle(30);
    chk("R3", "ready after 16x glitch", ready, 0);
    os8 = 1'b1;
    samp(1'b0); samp(1'b0); idle(20);
    chk("R3", "ready after 8x glitch", ready, 0);

    // R4: plain characters, both rates
    os8 = 1'b0; send_char(9'h0A5, -1, 0, 0, 0); idle(2);
    expect_char("R4", 9'h0A5, 0, 0, 0, 0); do_read("R9");
    os8 = 1'b1; send_char(9'h03C, -1, 0, 0, 0); idle(2);
    expect_char("R4", 9'h03C, 0, 0, 0, 0); do_read("R9");

    // R8: one high sample in the start vote, one flip on a data vote
    os8 = 1'b0; send_char(9'h081, 0, 5, 0, 0); idle(2);
    expect_char("R8", 9'h081, 1, 0, 0, 0); do_read("R8");
    send_char(9'h055, 3, 9, 0, 0); idle(2);
    expect_char("R8", 9'h055, 1, 0, 0, 0); do_read("R8");
    send_char(9'h055, 3, 12, 0, 0); idle(2);
    expect_char("R4", 9'h055, 0, 0, 0, 0); do_read("R4");

    // R5: word length
    nine = 1'b1; send_char(9'h1C3, -1, 0, 0, 0); idle(2);
    expect_char("R5", 9'h1C3, 0, 0, 0, 0); do_read("R5");
    nine = 1'b0; send_char(9'h1FF, -1, 0, 0, 0); idle(2);
    chk("R5", "bit8 in 8-bit mode", data[8], 0);
    expect_char("R5", 9'h1FF, 0, 0, 0, 0); do_read("R5");

    // R6: parity even good, odd good, bad
    pen = 1'b1; podd = 1'b0; send_char(9'h037, -1, 0, 0, 0); idle(2);
    expect_char("R6", 9'h037, 0, 0, 0, 0); do_read("R6");
    podd = 1'b1; send_char(9'h037, -1, 0, 0, 0); idle(2);
    expect_char("R6", 9'h037, 0, 0, 0, 0); do_read("R6");
    send_char(9'h0E1, -1, 0, 1, 0); idle(2);
    expect_char("R6", 9'h0E1, 0, 0, 1, 0); do_read("R6");
    pen = 1'b0;

    // R7: low stop bit
    send_char(9'h0F0, -1, 0, 0, 1); idle(4);
    expect_char("R7", 9'h0F0, 0, 1, 0, 0); do_read("R7");

    // R10: overrun keeps the first character
    send_char(9'h011, -1, 0, 0, 0); idle(3);
    send_char(9'h0EE, -1, 0, 0, 1); idle(4);
    expect_char("R10", 9'h011, 0, 0, 0, 1); do_read("R10");

    // R11: back-to-back at both rates (second one shows as overrun)
    for (int r = 0; r < 2; r++) begin
      os8 = r[0];
      send_char(9'h0C6, -1, 0, 0, 0);
      send_char(9'h039, -1, 0, 0, 0); idle(2);
      expect_char("R11", 9'h0C6, 0, 0, 0, 1); do_read("R11");
    end

    // random characters
    for (int k = 0; k < 40; k++) begin
      os8 = $urandom % 2; nine = $urandom % 2; pen = $urandom % 2; podd = $urandom % 2;
      a = 9'($urandom);
      bp = pen && ($urandom % 5 == 0);
      fb = -1; fp = 0; en = 1'b0;
      nb = nine ? 9 : 8;
      if ($urandom % 2) begin
        fb = $urandom_range(0, nb + (pen ? 1 : 0));
        fp = $urandom_range(2, nsamp());
        en = is_vote(fb, fp);
      end
      idle($urandom_range(0, 3));
      send_char(a, fb, fp, bp, 0); idle(1);
      expect_char(en ? "R8" : (pen ? "R6" : "R4"), a, en, 0, bp, 0);
      do_read("R9");
    end
    b = 9'h000;
    chk("R9", "final ready", ready, int'(b[0]));

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule